// File: doc/BRIEF.md
# Convertible J-K/D Register Bank

This block is a bank of registered output cells that share one rising-edge clock. Each cell holds one flip-flop, and its J and K inputs come from sum terms computed elsewhere. A cell can be configured as J-K only, or as J-K-or-D. A J-K-or-D cell turns into a D flip-flop whenever the global fold-back control `fc` is high, because its K then follows the inverse of J. Each cell drives its pin with the inverse of its internal state, and it feeds the internal state back to the logic array.

The cells form groups. Each group shares one asynchronous preset term, one reset term, a load term and an output-enable term. The load term preloads the register from the value forced on the pin. A two-bit enable code for each group decides how the pin drivers are enabled. The three-state pin is split into a drive value, an enable and a sampled input, so the block can be synthesized. No data stream passes through the block, so it has no valid/ready interface. All pins are plain control and data levels.

Top module: `jkd_regbank`

## Requirements
- R1: When a cell behaves as J-K, a rising edge with J=0,K=0 holds Q. J=0,K=1 clears Q. J=1,K=0 sets Q. J=1,K=1 inverts Q.
- R2: A cell with `cfg_jk_only` bit 0 and `fc`=1 uses K = not J, so Q takes the value of J after the edge.
- R3: A cell with `cfg_jk_only` bit 1 follows the J-K table of R1 whatever the value of `fc`.
- R4: Group g covers cells g*(NCELL/NGRP) to (g+1)*(NCELL/NGRP)-1. While `preset[g]` is high, the Q of those cells is 1. While only `clr_term[g]` is high, Q is 0. With both terms high, Q is 1. Other groups are not affected.
- R5: When `load_term[g]` is high at a rising edge and no preset or reset is active, every cell of the group captures Q = not `pin_in`, so that the pin afterwards shows the forced value. This overrides J and K.
- R6: While `rst_n` is low, every Q is 0 and every `pin_out` bit is 1.
- R7: `pin_out` is always the bitwise inverse of `q_fb`.
- R8: Group g's enable code is `cfg_en[2g+1:2g]`. Code 0 (idle) and code 2 (on) enable the pins. Code 3 (off) disables them. Code 1 (control) enables them only when `en_term[g]` is 1 and `oe_n` is 0.
- R9: While `load_term[g]` is high, the pins of group g are disabled regardless of the enable code.
- R10: Preset and reset act without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_jk_only | input | NCELL | Per-cell configuration: 1 = J-K only, 0 = J-K or D |
| cfg_en | input | 2*NGRP | Per-group enable code |
| j_sum | input | NCELL | J sum for each cell |
| k_sum | input | NCELL | K sum for each cell |
| fc | input | 1 | Global fold-back control (D mode) |
| preset | input | NGRP | Asynchronous preset term for each group |
| clr_term | input | NGRP | Asynchronous reset term for each group |
| load_term | input | NGRP | Pin preload term for each group |
| en_term | input | NGRP | Output-enable term for each group |
| oe_n | input | 1 | Output-enable pin, active low |
| pin_in | input | NCELL | Value sampled from each pin |
| q_fb | output | NCELL | Internal flip-flop state, fed back to the array |
| pin_out | output | NCELL | Pin drive value |
| pin_oe | output | NCELL | Pin driver enable |

## Verification
The bench uses the default sizes of eight cells in two groups and sets the J-K-only mask to a mix of ones and zeros, so every cell meets both modes. Each cell is preloaded to a computed starting state through the load path. It is then stepped through all combinations of state, J, K and `fc`, which covers the J-K, toggle and D behaviours on every cell. The two-group split lets the bench show that a preset/reset in one group leaves the other group untouched. It also sweeps every enable code against `oe_n`, the enable term and the load term.

// File: rtl/jkd_pkg.sv
package jkd_pkg;
  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_CTRL = 2'd1,
    EN_ON   = 2'd2,
    EN_OFF  = 2'd3
  } en_code_e;
endpackage

// File: rtl/jkd_cell.sv
module jkd_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  input  logic fc,
  input  logic jk_only,
  input  logic pre,
  input  logic clr,
  input  logic ld,
  input  logic pin_in,
  output logic q
);
  logic k_eff;
  logic frc;
  logic frc_val;
  logic q_r;
  logic nxt;

  // fold-back: in D mode K is the inverse of J
  assign k_eff   = (fc && !jk_only) ? ~j : k;
  // asynchronous overrides: power-on reset, then preset, then reset
  assign frc     = !rst_n || pre || clr;
  assign frc_val = rst_n && pre;

  always_comb begin
    if (ld) nxt = ~pin_in;
    else begin
      case ({j, k_eff})
        2'b00:   nxt = q_r;
        2'b01:   nxt = 1'b0;
        2'b10:   nxt = 1'b1;
        default: nxt = ~q_r;
      endcase
    end
  end

  always_ff @(posedge clk or posedge frc) begin
    if (frc) q_r <= frc_val;
    else     q_r <= nxt;
  end

  assign q = frc ? frc_val : q_r;

  // R4: preset wins over reset
  p_preset_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> q);
  // R1: J=K=0 in J-K behaviour holds state
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !frc && !j && !k && (jk_only || !fc)) |=> (pre || clr || q == $past(q)));
  // R2: D mode follows J
  p_dmode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !frc && fc && !jk_only) |=> (pre || clr || q == $past(j)));
  // R5: preload captures the inverse of the pin
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !frc) |=> (pre || clr || q == !$past(pin_in)));
endmodule

// File: rtl/jkd_oe_ctrl.sv
module jkd_oe_ctrl
  import jkd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic       en_term,
  input  logic       oe_n,
  input  logic       ld,
  output logic       oe
);
  en_code_e c;
  logic     base;

  assign c = en_code_e'(code);

  always_comb begin
    case (c)
      EN_IDLE: base = 1'b1;
      EN_ON:   base = 1'b1;
      EN_CTRL: base = en_term && !oe_n;
      default: base = 1'b0;
    endcase
  end

  // preload needs the pin released
  assign oe = base && !ld;

  // R9: load forces the drivers off
  p_load_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !oe);
  // R8: off code never enables
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'd3) |-> !oe);
endmodule

// File: rtl/jkd_regbank.sv
module jkd_regbank #(
  parameter int NCELL = 8,
  parameter int NGRP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCELL-1:0]  cfg_jk_only,
  input  logic [2*NGRP-1:0] cfg_en,
  input  logic [NCELL-1:0]  j_sum,
  input  logic [NCELL-1:0]  k_sum,
  input  logic              fc,
  input  logic [NGRP-1:0]   preset,
  input  logic [NGRP-1:0]   clr_term,
  input  logic [NGRP-1:0]   load_term,
  input  logic [NGRP-1:0]   en_term,
  input  logic              oe_n,
  input  logic [NCELL-1:0]  pin_in,
  output logic [NCELL-1:0]  q_fb,
  output logic [NCELL-1:0]  pin_out,
  output logic [NCELL-1:0]  pin_oe
);
  localparam int GSZ = NCELL / NGRP;

  logic [NGRP-1:0] grp_oe;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    jkd_oe_ctrl u_oe (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (cfg_en[2*g +: 2]),
      .en_term (en_term[g]),
      .oe_n    (oe_n),
      .ld      (load_term[g]),
      .oe      (grp_oe[g])
    );
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    localparam int G = i / GSZ;
    jkd_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .j       (j_sum[i]),
      .k       (k_sum[i]),
      .fc      (fc),
      .jk_only (cfg_jk_only[i]),
      .pre     (preset[G]),
      .clr     (clr_term[G]),
      .ld      (load_term[G]),
      .pin_in  (pin_in[i]),
      .q       (q_fb[i])
    );
    assign pin_out[i] = ~q_fb[i];
    assign pin_oe[i]  = grp_oe[G];
  end
endmodule

// File: tb/sim_jkd_regbank.sv
module sim_jkd_regbank;
  localparam int NCELL = 8;
  localparam int NGRP  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCELL-1:0] cfg_jk_only = 8'hA5;
  logic [2*NGRP-1:0] cfg_en = '0;
  logic [NCELL-1:0] j_sum = '0, k_sum = '0, pin_in = '0;
  logic fc = 1'b0, oe_n = 1'b0;
  logic [NGRP-1:0] preset = '0, clr_term = '0, load_term = '0, en_term = '0;
  logic [NCELL-1:0] q_fb, pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  jkd_regbank #(.NCELL(NCELL), .NGRP(NGRP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_jk_only(cfg_jk_only), .cfg_en(cfg_en),
    .j_sum(j_sum), .k_sum(k_sum), .fc(fc), .preset(preset),
    .clr_term(clr_term), .load_term(load_term), .en_term(en_term),
    .oe_n(oe_n), .pin_in(pin_in), .q_fb(q_fb), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [NCELL-1:0] act,
                     input logic [NCELL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCELL-1:0] model(input logic [NCELL-1:0] q,
      input logic [NCELL-1:0] j, input logic [NCELL-1:0] k,
      input logic f, input logic [NCELL-1:0] jko);
    logic [NCELL-1:0] r;
    for (int i = 0; i < NCELL; i++) begin
      logic ke;
      ke = (f && !jko[i]) ? !j[i] : k[i];
      case ({j[i], ke})
        2'b00: r[i] = q[i];
        2'b01: r[i] = 1'b0;
        2'b10: r[i] = 1'b1;
        default: r[i] = !q[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic exp_oe(input logic [1:0] c, input logic e,
                                  input logic o, input logic l);
    if (l) return 1'b0;
    case (c)
      2'd0, 2'd2: return 1'b1;
      2'd1: return e && !o;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NCELL-1:0] qi, jv, kv;
    // R6: power-on state
    #5;
    chk("R6 q", q_fb, 8'h00);
    chk("R6 pin", pin_out, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after release", q_fb, 8'h00);

    // R1 R2 R3 R5 R7 sweep
    for (int f = 0; f < 2; f++) begin
      for (int idx = 0; idx < 64; idx++) begin
        qi = 8'(idx * 29 + 7);
        jv = 8'(idx * 53) ^ 8'h5A;
        kv = 8'(idx * 101 + 3);
        pin_in = ~qi; load_term = 2'b11; j_sum = jv; k_sum = kv; fc = f[0];
        @(negedge clk);
        chk("R5 preload", q_fb, qi);
        load_term = 2'b00;
        @(negedge clk);
        chk(f ? "R1 R2 R3 jk/d step" : "R1 R3 jk step", q_fb,
            model(qi, jv, kv, f[0], cfg_jk_only));
        chk("R7 pin inverse", pin_out, ~q_fb);
      end
    end
    j_sum = '0; k_sum = '0; fc = 1'b0;

    // R4 R10 asynchronous preset/reset between clock edges
    pin_in = 8'hFF; load_term = 2'b11;
    @(negedge clk);
    load_term = 2'b00;
    @(negedge clk);
    chk("R4 start", q_fb, 8'h00);
    @(posedge clk); #5;
    preset[0] = 1'b1; #2;
    chk("R10 R4 preset grp A", q_fb, 8'h0F);
    clr_term[0] = 1'b1; #2;
    chk("R4 both active", q_fb, 8'h0F);
    preset[0] = 1'b0; #2;
    chk("R4 reset only", q_fb, 8'h00);
    preset[1] = 1'b1; #2;
    chk("R10 R4 preset grp B", q_fb, 8'hF0);
    @(negedge clk);
    clr_term[0] = 1'b0;
    @(negedge clk);
    preset[1] = 1'b0; #1;
    chk("R4 held after release", q_fb, 8'hF0);
    @(negedge clk);
    chk("R1 hold after release", q_fb, 8'hF0);

    // R5 load overrides J/K
    j_sum = 8'hFF; k_sum = 8'hFF; pin_in = 8'h3C; load_term = 2'b11;
    @(negedge clk);
    chk("R5 load over jk", q_fb, 8'hC3);
    load_term = 2'b00; j_sum = '0; k_sum = '0;

    // R8 R9 enable sweep
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 8; v++) begin
        logic [NCELL-1:0] e;
        cfg_en = {2'(3 - c), 2'(c)};
        en_term = {v[0], v[0]};
        oe_n = v[1];
        load_term = {1'b0, v[2]};
        #2;
        e = {{4{exp_oe(2'(3 - c), v[0], v[1], 1'b0)}},
             {4{exp_oe(2'(c), v[0], v[1], v[2])}}};
        chk(v[2] ? "R9 load disables" : "R8 enable code", pin_oe, e);
        @(negedge clk);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule